// File: doc/BRIEF.md
# Byte-Pair Word Sender with Ready/Acknowledge Handshake

The block lets an 8-bit host hand 16-bit words to a receiving computer over a parallel output. The host first writes the lower byte into a staging register. It then writes the upper byte. That second write commits the transfer: the full word appears on the 16-bit output in the same clock edge, and a busy flag is raised. After a programmable settling interval a data-ready strobe rises. This lets the receiver latch a word that has been stable for a known number of cycles.

The receiver answers with an acknowledge pulse. The pulse is brought into the clock domain by a two-flop synchronizer and its rising edge is detected. The rising edge drops data-ready and clears busy. The host polls a status register and sends the next word only when the busy bit reads 0. The exchange repeats word by word until the last word has been sent.

An upper-byte write that arrives while a word is still pending is dropped and raises a sticky error flag. A status read clears that flag. Lower-byte writes are always accepted into staging and never disturb the word on the output.

Top module: `word_strobe_port`

## Requirements
- R1: After reset the output word is 0, ready is low, and the status register (address 2) reads 0.
- R2: A write to address 0 stores the lower byte in staging only. A write to address 1 while not busy loads {written byte, staged byte} onto the output word at that clock edge and sets busy (status bit 0).
- R3: While busy, the output word does not change. Writes to address 0 while busy still update staging.
- R4: Ready rises exactly SETTLE_CYCLES clock edges after the committing edge (default 4), and it is high only while busy.
- R5: An acknowledge input sampled high at edge a, while ready is high, clears ready and busy at edge a+2 (two synchronizer flops plus rising-edge detection). Holding acknowledge high counts as one event.
- R6: An acknowledge rising edge seen while ready is low (idle, or still settling) has no effect.
- R7: A write to address 1 while busy is ignored, and it sets the error flag (status bit 1).
- R8: The error flag stays set until a status read at address 2 clears it. If a new error and a status read fall in the same cycle, the flag ends set.
- R9: Reads are registered: rd_data updates at the edge that samples rd_en. Address 0 returns the staged lower byte, address 1 the upper byte of the output word, address 2 the status {6'b0, error, busy}, and address 3 returns 0. Writes to addresses 2 and 3 change nothing.
- R10: Transfers repeat back to back. Each committed word runs through the same commit, settle, ready and acknowledge sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 2 | Host write register address |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read register address |
| rd_data | output | 8 | Registered read result |
| word_o | output | 16 | Parallel word to the receiver |
| ready_o | output | 1 | Data-ready strobe to the receiver |
| ack_i | input | 1 | Asynchronous acknowledge from the receiver |

## Verification
The bench measures the number of edges from the committing write to ready. A miscounted settle counter shows up as ready that is one cycle early or late. It sends acknowledge pulses while idle and while the word is still settling. A design that did not gate acknowledge on ready would drop busy before the receiver could take the word. It sends an upper-byte write during a pending transfer, including one in the same cycle as a status read. A wrong design would either corrupt the output word, lose the error flag, or let the read-clear win over the new error. Randomised words then run the full handshake many times in a row, so any leftover state from one transfer that leaks into the next shows up.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_STAT = 2'd2;

    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_WAIT   = 2'd2
    } phase_e;
endpackage

// File: rtl/wsp_edge_sync.sv
module wsp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/wsp_strobe_fsm.sv
module wsp_strobe_fsm
    import wsp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_i,
    input  logic ack_rise_i,
    output logic busy_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.phase)
            PH_IDLE: begin
                if (commit_i) begin
                    f_d.phase = PH_SETTLE;
                    f_d.cnt   = CNT_LOAD;
                end
            end
            PH_SETTLE: begin
                if (f_q.cnt == '0) begin
                    f_d.phase = PH_WAIT;
                    f_d.ready = 1'b1;
                end else begin
                    f_d.cnt = f_q.cnt - CNT_W'(1);
                end
            end
            PH_WAIT: begin
                if (ack_rise_i) begin
                    f_d.phase = PH_IDLE;
                    f_d.ready = 1'b0;
                end
            end
            default: begin
                f_d.phase = PH_IDLE;
                f_d.ready = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.phase <= PH_IDLE;
            f_q.cnt   <= '0;
            f_q.ready <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign busy_o  = (f_q.phase != PH_IDLE);
    assign ready_o = f_q.ready;
endmodule

// File: rtl/wsp_host_regs.sv
module wsp_host_regs
    import wsp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                busy_i,
    output logic                commit_o,
    output logic                err_o,
    output logic [2*BYTE_W-1:0] word_o,
    output logic [BYTE_W-1:0]   rd_data_o
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] stage;
        logic [WORD_W-1:0] word;
        logic              err;
        logic [BYTE_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_lo, hit_hi, stat_rd;
    logic [BYTE_W-1:0] stat_vec;

    always_comb begin
        hit_lo   = wr_en && (wr_addr == REG_LO);
        hit_hi   = wr_en && (wr_addr == REG_HI);
        stat_rd  = rd_en && (rd_addr == REG_STAT);
        commit_o = hit_hi && !busy_i;

        stat_vec          = '0;
        stat_vec[ST_BUSY] = busy_i;
        stat_vec[ST_ERR]  = r_q.err;

        r_d = r_q;
        if (hit_lo)   r_d.stage = wr_data;
        if (commit_o) r_d.word  = {wr_data, r_q.stage};

        if (hit_hi && busy_i) r_d.err = 1'b1;
        else if (stat_rd)     r_d.err = 1'b0;

        if (rd_en) begin
            case (rd_addr)
                REG_LO:   r_d.rdata = r_q.stage;
                REG_HI:   r_d.rdata = r_q.word[WORD_W-1:BYTE_W];
                REG_STAT: r_d.rdata = stat_vec;
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign err_o     = r_q.err;
    assign word_o    = r_q.word;
    assign rd_data_o = r_q.rdata;
endmodule

// File: rtl/word_strobe_port.sv
module word_strobe_port
    import wsp_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int SETTLE_CYCLES = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [2*BYTE_W-1:0] word_o,
    output logic                ready_o,
    input  logic                ack_i
);
    logic busy;
    logic err;
    logic commit;
    logic ack_rise;

    wsp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ack_i),
        .rise_o  (ack_rise)
    );

    wsp_host_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .busy_i    (busy),
        .commit_o  (commit),
        .err_o     (err),
        .word_o    (word_o),
        .rd_data_o (rd_data)
    );

    wsp_strobe_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .ack_rise_i (ack_rise),
        .busy_o     (busy),
        .ready_o    (ready_o)
    );
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker
    import wsp_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int SETTLE_CYCLES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [2*BYTE_W-1:0] word_o,
    input logic                ready_o,
    input logic                busy,
    input logic                err
);
    localparam int CW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYCLES + 1);

    logic [CW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= '0;
        else if (!busy)          since_q <= '0;
        else if (since_q != CMAX) since_q <= since_q + CW'(1);
    end

    a_r4_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> busy);

    a_r4_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (since_q == CW'(SETTLE_CYCLES)));

    a_r2_commit_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_HI && !busy) |=> busy);

    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(word_o));

    a_r7_busy_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_HI && busy) |=> err);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(rd_en && rd_addr == REG_STAT)) |=> err);

    a_r5_drop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> !busy);
endmodule

bind word_strobe_port wsp_checker #(
    .BYTE_W        (BYTE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .word_o  (word_o),
    .ready_o (ready_o),
    .busy    (busy),
    .err     (err)
);

// File: tb/word_strobe_port_bench.sv
module word_strobe_port_bench;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] word_o;
    logic        ready_o;
    logic        ack_i = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    word_strobe_port #(.SETTLE_CYCLES(SETTLE)) u_word_strobe_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .word_o(word_o), .ready_o(ready_o), .ack_i(ack_i)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_status(input bit e, input bit b);
        return {6'b0, e, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready_o && n < 64) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_ack(input string req);
        pulse_ack();
        @(negedge clk);
        chk({req, " ready held one edge after ack"}, 32'(ready_o), 32'd1);
        @(negedge clk);
        chk({req, " ready dropped"}, 32'(ready_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [15:0] exp_word;
        logic [7:0]  exp_stage;
        int n;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 word", 32'(word_o), 32'h0);
        chk("R1 ready", 32'(ready_o), 32'h0);
        do_read(2'd2, rv);
        chk("R1 status", 32'(rv), 32'(exp_status(0, 0)));

        // R2 staging then commit
        do_write(2'd0, 8'h34);
        chk("R2 staging leaves word", 32'(word_o), 32'h0);
        do_read(2'd0, rv);
        chk("R9 read staged byte", 32'(rv), 32'h34);
        do_write(2'd1, 8'h12);
        chk("R2 committed word", 32'(word_o), 32'h1234);
        wait_ready(n);
        chk("R4 settle edges", 32'(n), 32'(SETTLE));
        do_read(2'd2, rv);
        chk("R2 busy set", 32'(rv), 32'(exp_status(0, 1)));
        do_read(2'd1, rv);
        chk("R9 read high byte", 32'(rv), 32'h12);

        // R3 low write while busy
        do_write(2'd0, 8'hAA);
        chk("R3 word held", 32'(word_o), 32'h1234);
        do_read(2'd0, rv);
        chk("R3 staging updated", 32'(rv), 32'hAA);

        // R7 high write while busy
        do_write(2'd1, 8'h55);
        chk("R7 word held", 32'(word_o), 32'h1234);
        do_read(2'd2, rv);
        chk("R7 error flagged", 32'(rv), 32'(exp_status(1, 1)));
        do_read(2'd2, rv);
        chk("R8 error cleared by read", 32'(rv), 32'(exp_status(0, 1)));

        // R8 set and read in same cycle: set wins
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h77;
        rd_en = 1'b1; rd_addr = 2'd2;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R8 read returns old flag", 32'(rd_data), 32'(exp_status(0, 1)));
        do_read(2'd2, rv);
        chk("R8 set beats clear", 32'(rv), 32'(exp_status(1, 1)));

        // R5 acknowledge
        finish_ack("R5");
        do_read(2'd2, rv);
        chk("R5 busy cleared", 32'(rv), 32'(exp_status(0, 0)));
        chk("R5 word kept", 32'(word_o), 32'h1234);

        // R6 ack while idle
        pulse_ack();
        repeat (3) @(negedge clk);
        chk("R6 idle ack ready", 32'(ready_o), 32'h0);
        do_read(2'd2, rv);
        chk("R6 idle ack status", 32'(rv), 32'(exp_status(0, 0)));

        // R6 ack during settling is ignored
        do_write(2'd1, 8'h55);
        chk("R2 commit uses staged byte", 32'(word_o), 32'h55AA);
        pulse_ack();
        @(negedge clk);
        wait_ready(n);
        chk("R6 ready still on schedule", 32'(n + 2), 32'(SETTLE));
        repeat (3) @(negedge clk);
        chk("R6 early ack ignored", 32'(ready_o), 32'h1);
        // R5 held acknowledge is one event
        ack_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 held ack clears ready", 32'(ready_o), 32'h0);
        ack_i = 1'b0;
        @(negedge clk);

        // R9 writes to status and unused address do nothing
        do_write(2'd2, 8'hFF);
        do_write(2'd3, 8'hFF);
        chk("R9 word unchanged", 32'(word_o), 32'h55AA);
        do_read(2'd2, rv);
        chk("R9 status unchanged", 32'(rv), 32'(exp_status(0, 0)));
        do_read(2'd3, rv);
        chk("R9 address 3 reads zero", 32'(rv), 32'h0);
        do_read(2'd0, rv);
        chk("R9 staging unchanged", 32'(rv), 32'hAA);

        // R10 randomized back-to-back transfers
        exp_word = word_o;
        for (int i = 0; i < 60; i++) begin
            bit dup;
            exp_stage = 8'($urandom);
            do_write(2'd0, exp_stage);
            chk("R10 no early change", 32'(word_o), 32'(exp_word));
            exp_word = {8'($urandom), exp_stage};
            do_write(2'd1, exp_word[15:8]);
            chk("R10 word", 32'(word_o), 32'(exp_word));
            wait_ready(n);
            chk("R10 settle", 32'(n), 32'(SETTLE));
            dup = ($urandom % 3) == 0;
            if (dup) do_write(2'd1, 8'($urandom));
            repeat ($urandom % 4) @(negedge clk);
            do_read(2'd2, rv);
            chk("R10 status while pending", 32'(rv), 32'(exp_status(dup, 1)));
            chk("R10 word held", 32'(word_o), 32'(exp_word));
            finish_ack("R10");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule